// File: doc/BRIEF.md
# Byte-Packing Block Transfer Engine

This engine sits between a 16-bit word FIFO and a byte-wide card data port. It moves data in either direction, one byte per clock at most. Toward the FIFO it packs two card bytes into one word. Toward the card it unpacks each word into bytes. Two counters track the transfer: a byte counter that spans one block, and a block counter that spans the whole transfer. Both counters are programmable. An odd block length leaves the final word of each block half used.

A command strobe starts a transfer or cancels one. A data-type command empties the FIFO, records the direction and arms the engine. Any other command disarms it. When the last byte of the last block has moved, the engine disarms itself, reloads its counters and raises a sticky done flag. The host side can push or pop FIFO words whenever the engine does not own that side. While a transfer is running, the running counters are visible at the outputs.

Top module: `byte_xfer_engine`

## Requirements
- R1: After reset the engine is idle with done low, both running counters read 1, and the FIFO is empty. Card-side `card_rx_ready_o` and `card_tx_valid_o` are low, and `host_wr_ready_o` is high.
- R2: A pulse on `cfg_len_we_i` sets the block length to (`cfg_wdata_i` AND 0x7FF) + 1 bytes, so bits 15:11 are ignored. The same pulse loads that value into the running byte counter.
- R3: A pulse on `cfg_cnt_we_i` sets the block count to (`cfg_wdata_i` AND 0x7FF) + 1. It loads the block counter with that count and reloads the byte counter with the block length.
- R4: `cmd_valid_i` with `cmd_data_i`=1 empties the FIFO, clears done, sets active and latches `cmd_rd_i` (1 = card to FIFO). `cmd_valid_i` with `cmd_data_i`=0 clears active and leaves the FIFO contents alone.
- R5: From the card, the first byte of each pair lands in bits 7:0 of a FIFO word and the second in bits 15:8. The word enters the FIFO once its last byte is accepted.
- R6: When the byte counter is 1 as a byte arrives from the card, that byte completes the word. With an odd block length, the last word of each block therefore carries zero in bits 15:8.
- R7: Toward the card, bits 7:0 of the head word go out first. Bits 15:8 go out only if the byte counter was above 1. The head word is popped after its last byte is sent.
- R8: `card_rx_ready_o` is low while a new word would start and the FIFO occupancy exceeds `af_level_i`. It is also low whenever the FIFO is full.
- R9: In the card-write direction, `card_tx_valid_o` stays low while the FIFO is empty.
- R10: After the last byte of the last block moves, active clears and done rises. The byte counter then reads the block length and the block counter reads the block count.
- R11: `byte_cnt_o` and `blk_cnt_o` show the running counters, which count down as bytes and blocks complete.
- R12: At most one byte moves per clock, and never in both directions at once. While `card_tx_valid_o` is high and `card_tx_ready_i` is low, the byte and its valid hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_len_we_i | input | 1 | Block length write strobe |
| cfg_cnt_we_i | input | 1 | Block count write strobe |
| cfg_wdata_i | input | 16 | Configuration write value |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_data_i | input | 1 | 1 = data-type command |
| cmd_rd_i | input | 1 | Direction for a data command, 1 = card to FIFO |
| af_level_i | input | 5 | Almost-full occupancy level |
| host_wr_valid_i | input | 1 | Host word push request |
| host_wr_data_i | input | 16 | Host word to push |
| host_wr_ready_o | output | 1 | FIFO accepts a host push |
| host_rd_valid_o | output | 1 | Head word available to the host |
| host_rd_data_o | output | 16 | Head word |
| host_rd_ready_i | input | 1 | Host pops the head word |
| card_rx_valid_i | input | 1 | Card offers a byte |
| card_rx_data_i | input | 8 | Byte from the card |
| card_rx_ready_o | output | 1 | Engine accepts the card byte |
| card_tx_valid_o | output | 1 | Engine offers a byte to the card |
| card_tx_data_o | output | 8 | Byte to the card |
| card_tx_ready_i | input | 1 | Card accepts the byte |
| xfer_active_o | output | 1 | Transfer in progress |
| xfer_done_o | output | 1 | Sticky end-of-transfer flag |
| byte_cnt_o | output | 12 | Running byte counter |
| blk_cnt_o | output | 12 | Running block counter |
| fifo_level_o | output | 6 | FIFO occupancy in words |

## Verification
The assertions assume three things about the inputs. No configuration write and no host push arrives while a transfer is active. A command never lands in the same cycle as a byte handshake that is meant to count. The card keeps its byte steady while it waits for ready. The stimulus respects all three. It writes the configuration and issues commands only while the card-side valid and ready are idle. It pushes host words only for card-write transfers. It changes each card byte only after a handshake. The ready and valid patterns on every side come from a seeded random source, so stalls and bursts interleave while transfers run with odd and even block lengths.

// File: rtl/byte_xfer_pkg.sv
`timescale 1ns/1ps
package byte_xfer_pkg;
  typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} phase_e;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;
endpackage

// File: rtl/word_fifo.sv
`timescale 1ns/1ps
module word_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + AW'(1);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i || clr_i));
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (!empty_o || clr_i));
endmodule

// File: rtl/xfer_counters.sv
`timescale 1ns/1ps
module xfer_counters #(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned CFG_W = 16,
  localparam int unsigned CNT_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             len_we_i,
  input  logic             cnt_we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic [CNT_W-1:0] blk_cnt_o,
  output logic             last_byte_o,
  output logic             xfer_last_o
);
  logic [CNT_W-1:0] len_q, num_q, byte_cnt_q, blk_cnt_q, new_val;
  logic             unused_cfg_hi;

  assign unused_cfg_hi = ^wdata_i[CFG_W-1:LEN_W];
  assign new_val = CNT_W'(wdata_i[LEN_W-1:0]) + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q      <= CNT_W'(1);
      num_q      <= CNT_W'(1);
      byte_cnt_q <= CNT_W'(1);
      blk_cnt_q  <= CNT_W'(1);
    end else if (len_we_i || cnt_we_i) begin
      if (len_we_i) len_q <= new_val;
      if (cnt_we_i) begin
        num_q     <= new_val;
        blk_cnt_q <= new_val;
      end
      byte_cnt_q <= len_we_i ? new_val : len_q;
    end else if (step_i) begin
      if (byte_cnt_q == CNT_W'(1)) begin
        byte_cnt_q <= len_q;
        blk_cnt_q  <= (blk_cnt_q == CNT_W'(1)) ? num_q : blk_cnt_q - CNT_W'(1);
      end else begin
        byte_cnt_q <= byte_cnt_q - CNT_W'(1);
      end
    end
  end

  assign byte_cnt_o  = byte_cnt_q;
  assign blk_cnt_o   = blk_cnt_q;
  assign last_byte_o = (byte_cnt_q == CNT_W'(1));
  assign xfer_last_o = step_i && last_byte_o && (blk_cnt_q == CNT_W'(1));

  p_cnt_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_cnt_q != '0) && (byte_cnt_q <= len_q) && (blk_cnt_q != '0) && (blk_cnt_q <= num_q));
  p_reload_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_last_o && !len_we_i && !cnt_we_i) |=> (byte_cnt_q == len_q) && (blk_cnt_q == num_q));
endmodule

// File: rtl/byte_packer.sv
`timescale 1ns/1ps
module byte_packer
  import byte_xfer_pkg::*;
#(
  parameter int unsigned LVL_W = 6,
  localparam int unsigned AF_W = LVL_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              from_card_i,
  input  logic              hold_i,
  input  logic              last_byte_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [AF_W-1:0]   af_level_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o,
  output logic              pop_o,
  output logic              step_o
);
  phase_e            phase_q;
  logic [BYTE_W-1:0] stage_q;
  logic              rd_en, wr_en, space_ok, rx_hs, tx_hs;

  assign rd_en = active_i && from_card_i && !hold_i;
  assign wr_en = active_i && !from_card_i && !hold_i;

  // a new word needs headroom below the almost-full mark; the second byte only a free slot
  assign space_ok = (phase_q == PH_HI) ? !fifo_full_i
                  : (!fifo_full_i && (level_i <= {1'b0, af_level_i}));

  assign rx_ready_o = rd_en && space_ok;
  assign rx_hs      = rx_valid_i && rx_ready_o;
  assign tx_valid_o = wr_en && !fifo_empty_i;
  assign tx_data_o  = (phase_q == PH_HI) ? head_i[WORD_W-1:BYTE_W] : head_i[BYTE_W-1:0];
  assign tx_hs      = tx_valid_o && tx_ready_i;

  assign push_o      = rx_hs && ((phase_q == PH_HI) || last_byte_i);
  assign push_data_o = (phase_q == PH_HI) ? {rx_data_i, stage_q} : {{BYTE_W{1'b0}}, rx_data_i};
  assign pop_o       = tx_hs && ((phase_q == PH_HI) || last_byte_i);
  assign step_o      = rx_hs || tx_hs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LO;
      stage_q <= '0;
    end else begin
      if (hold_i) begin
        phase_q <= PH_LO;
      end else if (step_o) begin
        phase_q <= ((phase_q == PH_LO) && !last_byte_i) ? PH_HI : PH_LO;
      end
      if (rx_hs && (phase_q == PH_LO)) stage_q <= rx_data_i;
    end
  end

  p_single_dir_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ready_o && tx_valid_o));
  p_hi_needs_bytes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && (phase_q == PH_LO) && last_byte_i) |=> (phase_q == PH_LO));
endmodule

// File: rtl/byte_xfer_engine.sv
`timescale 1ns/1ps
module byte_xfer_engine
  import byte_xfer_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned CFG_W      = 16,
  localparam int unsigned AW        = $clog2(FIFO_DEPTH),
  localparam int unsigned LVL_W     = AW + 1,
  localparam int unsigned CNT_W     = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_len_we_i,
  input  logic              cfg_cnt_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_data_i,
  input  logic              cmd_rd_i,
  input  logic [AW-1:0]     af_level_i,
  input  logic              host_wr_valid_i,
  input  logic [WORD_W-1:0] host_wr_data_i,
  output logic              host_wr_ready_o,
  output logic              host_rd_valid_o,
  output logic [WORD_W-1:0] host_rd_data_o,
  input  logic              host_rd_ready_i,
  input  logic              card_rx_valid_i,
  input  logic [BYTE_W-1:0] card_rx_data_i,
  output logic              card_rx_ready_o,
  output logic              card_tx_valid_o,
  output logic [BYTE_W-1:0] card_tx_data_o,
  input  logic              card_tx_ready_i,
  output logic              xfer_active_o,
  output logic              xfer_done_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic [CNT_W-1:0]  blk_cnt_o,
  output logic [LVL_W-1:0]  fifo_level_o
);
  logic              active_q, from_card_q, done_q;
  logic              fifo_clr, fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [WORD_W-1:0] fifo_wdata, fifo_head, eng_wdata;
  logic [LVL_W-1:0]  fifo_level;
  logic              eng_push, eng_pop, eng_step, last_byte, xfer_last;
  logic              host_push, host_pop;

  // the engine owns the FIFO side facing its current direction
  assign host_wr_ready_o = !fifo_full && !(active_q && from_card_q);
  assign host_rd_valid_o = !fifo_empty && !(active_q && !from_card_q);
  assign host_push       = host_wr_valid_i && host_wr_ready_o;
  assign host_pop        = host_rd_valid_i_int();
  function automatic logic host_rd_valid_i_int();
    return host_rd_valid_o && host_rd_ready_i;
  endfunction

  assign fifo_clr   = cmd_valid_i && cmd_data_i;
  assign fifo_push  = eng_push || host_push;
  assign fifo_wdata = eng_push ? eng_wdata : host_wr_data_i;
  assign fifo_pop   = eng_pop || host_pop;

  word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (fifo_clr),
    .push_i      (fifo_push),
    .push_data_i (fifo_wdata),
    .pop_i       (fifo_pop),
    .head_o      (fifo_head),
    .level_o     (fifo_level),
    .full_o      (fifo_full),
    .empty_o     (fifo_empty)
  );

  xfer_counters #(.LEN_W(LEN_W), .CFG_W(CFG_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .len_we_i    (cfg_len_we_i),
    .cnt_we_i    (cfg_cnt_we_i),
    .wdata_i     (cfg_wdata_i),
    .step_i      (eng_step),
    .byte_cnt_o  (byte_cnt_o),
    .blk_cnt_o   (blk_cnt_o),
    .last_byte_o (last_byte),
    .xfer_last_o (xfer_last)
  );

  byte_packer #(.LVL_W(LVL_W)) u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (active_q),
    .from_card_i  (from_card_q),
    .hold_i       (cmd_valid_i),
    .last_byte_i  (last_byte),
    .fifo_full_i  (fifo_full),
    .fifo_empty_i (fifo_empty),
    .level_i      (fifo_level),
    .af_level_i   (af_level_i),
    .head_i       (fifo_head),
    .rx_valid_i   (card_rx_valid_i),
    .rx_data_i    (card_rx_data_i),
    .rx_ready_o   (card_rx_ready_o),
    .tx_valid_o   (card_tx_valid_o),
    .tx_data_o    (card_tx_data_o),
    .tx_ready_i   (card_tx_ready_i),
    .push_o       (eng_push),
    .push_data_o  (eng_wdata),
    .pop_o        (eng_pop),
    .step_o       (eng_step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      from_card_q <= 1'b0;
      done_q      <= 1'b0;
    end else if (cmd_valid_i) begin
      active_q <= cmd_data_i;
      if (cmd_data_i) begin
        from_card_q <= cmd_rd_i;
        done_q      <= 1'b0;
      end
    end else if (xfer_last) begin
      active_q <= 1'b0;
      done_q   <= 1'b1;
    end
  end

  assign host_rd_data_o = fifo_head;
  assign xfer_active_o  = active_q;
  assign xfer_done_o    = done_q;
  assign fifo_level_o   = fifo_level;

  p_cmd_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_data_i) |=> (xfer_active_o && (fifo_level_o == '0) && !xfer_done_o));
  p_rx_no_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rx_ready_o |-> (fifo_level_o < LVL_W'(FIFO_DEPTH)));
  p_tx_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_level_o == '0) |-> !card_tx_valid_o);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> !xfer_active_o);
  p_tx_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_tx_valid_o && !card_tx_ready_i) |=>
      (cmd_valid_i || (card_tx_valid_o && $stable(card_tx_data_o))));
endmodule

// File: tb/byte_xfer_engine_bench.sv
`timescale 1ns/1ps
module byte_xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_len_we = 1'b0, cfg_cnt_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        cmd_valid = 1'b0, cmd_data = 1'b0, cmd_rd = 1'b0;
  logic [4:0]  af_level = 5'd31;
  logic        host_wr_valid = 1'b0;
  logic [15:0] host_wr_data = '0;
  logic        host_wr_ready, host_rd_valid, host_rd_ready = 1'b0;
  logic [15:0] host_rd_data;
  logic        card_rx_valid = 1'b0, card_rx_ready;
  logic [7:0]  card_rx_data = '0, card_tx_data;
  logic        card_tx_valid, card_tx_ready = 1'b0;
  logic        xfer_active, xfer_done;
  logic [11:0] byte_cnt, blk_cnt;
  logic [5:0]  fifo_level;

  int checks = 0;
  int errors = 0;

  logic [7:0]  byte_arr [4096];
  logic [15:0] word_arr [4096];
  bit          odd_arr  [4096];
  int          n_bytes, n_words;

  always #2 clk = ~clk;

  byte_xfer_engine u_byte_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_len_we_i(cfg_len_we), .cfg_cnt_we_i(cfg_cnt_we), .cfg_wdata_i(cfg_wdata),
    .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_rd_i(cmd_rd),
    .af_level_i(af_level),
    .host_wr_valid_i(host_wr_valid), .host_wr_data_i(host_wr_data), .host_wr_ready_o(host_wr_ready),
    .host_rd_valid_o(host_rd_valid), .host_rd_data_o(host_rd_data), .host_rd_ready_i(host_rd_ready),
    .card_rx_valid_i(card_rx_valid), .card_rx_data_i(card_rx_data), .card_rx_ready_o(card_rx_ready),
    .card_tx_valid_o(card_tx_valid), .card_tx_data_o(card_tx_data), .card_tx_ready_i(card_tx_ready),
    .xfer_active_o(xfer_active), .xfer_done_o(xfer_done),
    .byte_cnt_o(byte_cnt), .blk_cnt_o(blk_cnt), .fifo_level_o(fifo_level)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen_byte(input int base, input int k);
    return 8'((base + k * 29 + (k >> 3)) & 255);
  endfunction

  // expected packing: pairs per block, odd tail word gets fill in the high half
  task automatic build(input int lv, input int nv, input int base, input logic [7:0] fill);
    int p = 0;
    n_words = 0;
    n_bytes = lv * nv;
    for (int k = 0; k < n_bytes; k++) byte_arr[k] = gen_byte(base, k);
    for (int b = 0; b < nv; b++) begin
      for (int i = 0; i < lv; i += 2) begin
        if (i + 1 < lv) begin
          word_arr[n_words] = {byte_arr[p+1], byte_arr[p]};
          odd_arr[n_words]  = 1'b0;
          p += 2;
        end else begin
          word_arr[n_words] = {fill, byte_arr[p]};
          odd_arr[n_words]  = 1'b1;
          p += 1;
        end
        n_words++;
      end
    end
  endtask

  task automatic cfg_len(input logic [15:0] v);
    @(negedge clk); cfg_len_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_len_we = 1'b0;
  endtask

  task automatic cfg_cnt(input logic [15:0] v);
    @(negedge clk); cfg_cnt_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_cnt_we = 1'b0;
  endtask

  task automatic issue(input logic d, input logic rd);
    @(negedge clk); cmd_valid = 1'b1; cmd_data = d; cmd_rd = rd;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic run_read(input int lv, input int nv, input int af);
    build(lv, nv, $urandom % 256, 8'h00);
    cfg_len(16'(lv - 1));
    cfg_cnt(16'(nv - 1));
    af_level = 5'(af);
    issue(1'b1, 1'b1);
    fork
      begin
        int k = 0;
        bit hs;
        while (k < n_bytes) begin
          @(negedge clk);
          card_rx_valid = ($urandom % 4) != 0;
          card_rx_data  = byte_arr[k];
          #1 hs = card_rx_valid && card_rx_ready;
          @(posedge clk);
          if (hs) k++;
        end
        @(negedge clk); card_rx_valid = 1'b0;
      end
      begin
        int w = 0;
        while (w < n_words) begin
          @(negedge clk);
          host_rd_ready = ($urandom % 3) != 0;
          #1;
          if (host_rd_valid && host_rd_ready) begin
            chk(host_rd_data == word_arr[w], odd_arr[w] ? "R6" : "R5", "packed word",
                host_rd_data, word_arr[w]);
            w++;
          end
          @(posedge clk);
        end
        @(negedge clk); host_rd_ready = 1'b0;
      end
    join
    @(negedge clk); #1;
    chk(!xfer_active && xfer_done, "R10", "idle and done after read", {xfer_active, xfer_done}, 1);
    chk(byte_cnt == 12'(lv), "R10", "byte counter reload", byte_cnt, lv);
    chk(blk_cnt == 12'(nv), "R10", "block counter reload", blk_cnt, nv);
    chk(fifo_level == 0, "R5", "all words drained", fifo_level, 0);
  endtask

  task automatic run_write(input int lv, input int nv);
    build(lv, nv, $urandom % 256, 8'hA5);
    cfg_len(16'(lv - 1));
    cfg_cnt(16'(nv - 1));
    issue(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    #1 chk(!card_tx_valid, "R9", "no byte offered from empty FIFO", card_tx_valid, 0);
    fork
      begin
        int w = 0;
        bit hs;
        while (w < n_words) begin
          @(negedge clk);
          host_wr_valid = ($urandom % 3) != 0;
          host_wr_data  = word_arr[w];
          #1 hs = host_wr_valid && host_wr_ready;
          @(posedge clk);
          if (hs) w++;
        end
        @(negedge clk); host_wr_valid = 1'b0;
      end
      begin
        int k = 0;
        bit stalled = 1'b0;
        logic [7:0] held = '0;
        while (k < n_bytes) begin
          @(negedge clk);
          card_tx_ready = ($urandom % 3) != 0;
          #1;
          if (stalled)
            chk(card_tx_valid && card_tx_data == held, "R12", "byte held under backpressure",
                card_tx_data, held);
          if (card_tx_valid && card_tx_ready) begin
            chk(card_tx_data == byte_arr[k], "R7", "byte order to card", card_tx_data, byte_arr[k]);
            k++;
          end
          stalled = card_tx_valid && !card_tx_ready;
          held    = card_tx_data;
          @(posedge clk);
        end
        @(negedge clk); card_tx_ready = 1'b0;
      end
    join
    @(negedge clk); #1;
    chk(!xfer_active && xfer_done, "R10", "idle and done after write", {xfer_active, xfer_done}, 1);
    chk(fifo_level == 0, "R7", "every word popped incl. half words", fifo_level, 0);
    chk(!card_tx_valid, "R7", "no extra byte sent", card_tx_valid, 0);
    chk(byte_cnt == 12'(lv) && blk_cnt == 12'(nv), "R10", "counters reloaded",
        {byte_cnt, blk_cnt}, {12'(lv), 12'(nv)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int acc;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!xfer_active && !xfer_done, "R1", "idle after reset", {xfer_active, xfer_done}, 0);
    chk(byte_cnt == 1 && blk_cnt == 1, "R1", "counters after reset", {byte_cnt, blk_cnt}, {12'd1, 12'd1});
    chk(fifo_level == 0 && !card_rx_ready && !card_tx_valid && host_wr_ready, "R1", "ports after reset",
        {fifo_level, card_rx_ready, card_tx_valid, host_wr_ready}, 1);

    run_read(4, 2, 31);
    run_read(3, 3, 31);
    run_read(1, 2, 31);
    run_read(2048, 1, 31);
    run_write(4, 2);
    run_write(5, 2);
    run_write(1, 3);
    for (int it = 0; it < 10; it++) begin
      int lv = 1 + $urandom % 9;
      int nv = 1 + $urandom % 4;
      if ($urandom % 2) run_read(lv, nv, $urandom % 32);
      else run_write(lv, nv);
    end

    // almost-full stall with no host pops
    cfg_len(16'd7);
    cfg_cnt(16'd0);
    af_level = 5'd1;
    issue(1'b1, 1'b1);
    acc = 0;
    for (int c = 0; c < 20; c++) begin
      bit hs;
      @(negedge clk);
      card_rx_valid = 1'b1;
      card_rx_data  = 8'(c);
      #1 hs = card_rx_ready;
      @(posedge clk);
      if (hs) acc++;
    end
    @(negedge clk); card_rx_valid = 1'b0; #1;
    chk(acc == 4, "R8", "bytes accepted before almost-full stall", acc, 4);
    chk(fifo_level == 2 && !card_rx_ready, "R8", "stalled above almost-full level",
        fifo_level, 2);
    chk(byte_cnt == 4 && blk_cnt == 1, "R11", "running counters mid block", byte_cnt, 4);
    issue(1'b0, 1'b0);
    #1 chk(!xfer_active && fifo_level == 2, "R4", "non-data command keeps FIFO",
           {xfer_active, fifo_level}, 2);
    chk(!xfer_done, "R4", "data command cleared done", xfer_done, 0);
    cfg_cnt(16'h8802);
    #1 chk(blk_cnt == 3 && byte_cnt == 8, "R3", "block count write reloads",
           {blk_cnt, byte_cnt}, {12'd3, 12'd8});
    cfg_len(16'hF805);
    #1 chk(byte_cnt == 6 && blk_cnt == 3, "R2", "length masked to 11 bits plus one",
           byte_cnt, 6);
    issue(1'b1, 1'b1);
    #1 chk(xfer_active && fifo_level == 0, "R4", "data command empties FIFO and arms",
           {xfer_active, fifo_level}, {1'b1, 6'd0});
    issue(1'b0, 1'b0);
    #1 chk(!xfer_active, "R4", "non-data command disarms", xfer_active, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule